// File: doc/BRIEF.md
# 32-bit Slice-Based ALU with Set-Less-Than

This block is a purely combinational arithmetic and logic unit for 32-bit operands. It is a chain of identical one-bit slices. Each slice can invert either operand, and it produces an AND, an OR and a full-adder sum. A multiplexer in each slice picks one of these, or a "less" input, as that slice's result bit. The carry ripples from the lowest slice to the highest.

A 4-bit control word picks the operation. Bit 3 inverts A. Bit 2 inverts B and also supplies the carry into the lowest slice, so a subtraction is A plus the complement of B plus one. Bits 1:0 pick the per-slice output.

For set-less-than, the top slice forms a "set" signal. This signal is the sign of A−B, corrected by signed overflow. It is fed back into the lowest slice's less input, and every other slice gets a constant zero. Besides the result, the block reports a zero flag for equality tests, the adder's carry-out and a signed-overflow flag.

Top module: `alu32_slt`

## Requirements
- R1: Control 4'b0000 gives result = A AND B.
- R2: Control 4'b0001 gives result = A OR B.
- R3: Control 4'b0010 gives result = (A + B) mod 2^32, and carry_o equals bit 32 of the unsigned 33-bit sum.
- R4: Control 4'b0110 gives result = (A − B) mod 2^32, and carry_o equals bit 32 of A + ~B + 1. That bit is 1 exactly when A ≥ B unsigned.
- R5: Control 4'b0111 gives result = 1 when A < B as signed two's-complement numbers, and 0 otherwise. This holds even when A−B overflows. Bits 31:1 are always zero.
- R6: Control 4'b1100 gives result = NOT (A OR B).
- R7: zero_o is 1 exactly when all 32 result bits are zero, for every control value.
- R8: overflow_o is 1 for add or subtract exactly when both adder inputs of the top slice share a sign that differs from the sum's sign. For every other control value, overflow_o and carry_o are 0.
- R9: Any control value other than the six listed gives result 0, carry_o 0, overflow_o 0 and zero_o 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ctrl_i | input | 4 | Operation select: invert-A, invert-B/carry-in, output pick[1:0] |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| carry_o | output | 1 | Adder carry out of bit 31 (add/subtract only) |
| overflow_o | output | 1 | Signed overflow (add/subtract only) |

## Verification
The bench drives uniformly random operand pairs across all six operation codes, so that the logic paths and the ripple carry meet arbitrary bit patterns. Directed pairs sit at the signed and unsigned boundaries: all-ones plus one, the largest positive value plus one, the most negative value minus one, and equal operands. These separate carry from overflow and show whether the zero flag follows the result. Set-less-than is tried on pairs whose difference overflows, where a check of the raw sign bit alone gives the wrong answer. Unassigned control codes are swept to confirm that the outputs stay quiet.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  localparam int CTRL_W = 4;

  typedef enum logic [CTRL_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  typedef enum logic [1:0] {
    PICK_AND  = 2'b00,
    PICK_OR   = 2'b01,
    PICK_SUM  = 2'b10,
    PICK_LESS = 2'b11
  } pick_e;

  typedef struct packed {
    logic  inv_a;
    logic  inv_b;
    pick_e pick;
    logic  legal;
  } slice_ctl_t;

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic signed_ovf(input logic xs, input logic ys, input logic ss);
    return (xs == ys) && (ss != xs);
  endfunction

endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import alu32_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output slice_ctl_t        ctl_o
);

  logic legal;

  always_comb begin
    unique case (ctrl_i)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR: legal = 1'b1;
      default:                                      legal = 1'b0;
    endcase
  end

  always_comb begin
    ctl_o.inv_a = ctrl_i[3];
    ctl_o.inv_b = ctrl_i[2];
    ctl_o.pick  = pick_e'(ctrl_i[1:0]);
    ctl_o.legal = legal;
  end

  always_comb begin
    if (ctl_o.legal && ctl_o.inv_a)
      AST_INV_A_ONLY_NOR: assert (ctl_o.inv_b && ctl_o.pick == PICK_AND); // R6
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu32_pkg::*;
(
  input  logic  a_i,
  input  logic  b_i,
  input  logic  cin_i,
  input  logic  less_i,
  input  logic  inv_a_i,
  input  logic  inv_b_i,
  input  pick_e pick_i,
  output logic  res_o,
  output logic  cout_o
);

  logic a_eff, b_eff, sum_bit;

  assign a_eff   = a_i ^ inv_a_i;
  assign b_eff   = b_i ^ inv_b_i;
  assign sum_bit = fa_sum(a_eff, b_eff, cin_i);
  assign cout_o  = fa_carry(a_eff, b_eff, cin_i);

  always_comb begin
    unique case (pick_i)
      PICK_AND:  res_o = a_eff & b_eff;
      PICK_OR:   res_o = a_eff | b_eff;
      PICK_SUM:  res_o = sum_bit;
      default:   res_o = less_i;
    endcase
  end

endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu32_pkg::*;
(
  input  logic  a_i,
  input  logic  b_i,
  input  logic  cin_i,
  input  logic  inv_a_i,
  input  logic  inv_b_i,
  input  pick_e pick_i,
  output logic  res_o,
  output logic  cout_o,
  output logic  set_o,
  output logic  ovf_o
);

  logic a_eff, b_eff, sum_bit;

  alu_slice u_core (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .less_i  (1'b0),
    .inv_a_i (inv_a_i),
    .inv_b_i (inv_b_i),
    .pick_i  (pick_i),
    .res_o   (res_o),
    .cout_o  (cout_o)
  );

  assign a_eff   = a_i ^ inv_a_i;
  assign b_eff   = b_i ^ inv_b_i;
  assign sum_bit = fa_sum(a_eff, b_eff, cin_i);
  assign ovf_o   = signed_ovf(a_eff, b_eff, sum_bit);
  assign set_o   = sum_bit ^ ovf_o;

  always_comb begin
    AST_OVF_IS_CARRY_MISMATCH: assert (ovf_o == (cin_i ^ cout_o)); // R8
  end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value_i,
  output logic             zero_o
);

  localparam int HALF = WIDTH / 2;

  logic lo_any, hi_any;

  assign lo_any = |value_i[HALF-1:0];
  assign hi_any = |value_i[WIDTH-1:HALF];
  assign zero_o = ~(lo_any | hi_any);

endmodule

// File: rtl/alu32_slt.sv
module alu32_slt
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              zero_o,
  output logic              carry_o,
  output logic              overflow_o
);

  localparam int MSB = WIDTH - 1;

  slice_ctl_t       ctl;
  logic [WIDTH:0]   carry_chain;
  logic [WIDTH-1:0] slice_res;
  logic             set_lt;
  logic             msb_ovf;
  logic             is_arith;
  logic             is_slt;

  alu_ctrl_decode u_dec (
    .ctrl_i (ctrl_i),
    .ctl_o  (ctl)
  );

  assign carry_chain[0] = ctl.inv_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == MSB) begin : g_top
      alu_msb_slice u_bit (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .cin_i   (carry_chain[i]),
        .inv_a_i (ctl.inv_a),
        .inv_b_i (ctl.inv_b),
        .pick_i  (ctl.pick),
        .res_o   (slice_res[i]),
        .cout_o  (carry_chain[i+1]),
        .set_o   (set_lt),
        .ovf_o   (msb_ovf)
      );
    end else begin : g_low
      alu_slice u_bit (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .cin_i   (carry_chain[i]),
        .less_i  ((i == 0) ? set_lt : 1'b0),
        .inv_a_i (ctl.inv_a),
        .inv_b_i (ctl.inv_b),
        .pick_i  (ctl.pick),
        .res_o   (slice_res[i]),
        .cout_o  (carry_chain[i+1])
      );
    end
  end

  assign is_arith   = ctl.legal && (ctl.pick == PICK_SUM);
  assign is_slt     = ctl.legal && (ctl.pick == PICK_LESS);
  assign result_o   = ctl.legal ? slice_res : '0;
  assign carry_o    = is_arith & carry_chain[WIDTH];
  assign overflow_o = is_arith & msb_ovf;

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .value_i (result_o),
    .zero_o  (zero_o)
  );

  always_comb begin
    AST_ZERO_FOLLOWS_RESULT: assert (zero_o == (result_o == '0)); // R7
    if (is_slt)
      AST_SLT_UPPER_CLEAR: assert (result_o[MSB:1] == '0); // R5
    if (!ctl.legal)
      AST_UNDEF_QUIET: assert (result_o == '0 && !carry_o && !overflow_o); // R9
    if (!is_arith)
      AST_NO_OVERFLOW: assert (!overflow_o && !carry_o); // R8
    if (ctrl_i == OP_ADD)
      AST_ADD_SUM: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i})); // R3
  end

endmodule

// File: tb/tb_alu32_slt.sv
module tb_alu32_slt;

  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  ctrl;
  logic [31:0] result;
  logic        zero, carry, ovf;
  int          n_checks = 0;
  int          n_errors = 0;
  int          cycles   = 0;
  bit          done     = 0;

  always #2 clk = ~clk;

  alu32_slt dut (
    .a_i        (a),
    .b_i        (b),
    .ctrl_i     (ctrl),
    .result_o   (result),
    .zero_o     (zero),
    .carry_o    (carry),
    .overflow_o (ovf)
  );

  function automatic logic [32:0] ref_wide(input logic [31:0] x, input logic [31:0] y,
                                           input logic [3:0] c);
    case (c)
      4'b0010: return {1'b0, x} + {1'b0, y};
      4'b0110: return {1'b0, x} + {1'b0, ~y} + 33'd1;
      default: return 33'd0;
    endcase
  endfunction

  function automatic logic [31:0] ref_result(input logic [31:0] x, input logic [31:0] y,
                                             input logic [3:0] c);
    case (c)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'b1100: return ~(x | y);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic ref_ovf(input logic [31:0] x, input logic [31:0] y,
                                   input logic [3:0] c);
    logic signed [32:0] wide;
    if (c == 4'b0010) wide = $signed({x[31], x}) + $signed({y[31], y});
    else if (c == 4'b0110) wide = $signed({x[31], x}) - $signed({y[31], y});
    else return 1'b0;
    return wide[32] != wide[31];
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s a=%h b=%h ctrl=%b actual=%h expected=%h", tag, a, b, ctrl, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [3:0] c);
    logic [32:0] w;
    logic [31:0] r;
    @(negedge clk);
    a = x; b = y; ctrl = c;
    #1;
    w = ref_wide(x, y, c);
    r = ref_result(x, y, c);
    check(tag_of(c), result, r);
    check("R7 zero", {31'd0, zero}, {31'd0, r == 32'd0});
    check((c == 4'b0110) ? "R4 carry" : (c == 4'b0010) ? "R3 carry" : "R8 carry",
          {31'd0, carry}, {31'd0, w[32]});
    check("R8 overflow", {31'd0, ovf}, {31'd0, ref_ovf(x, y, c)});
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    logic [3:0] ops [6];
    logic [3:0] undef [4];
    void'($urandom(32'd1234));
    ops[0] = 4'b0000; ops[1] = 4'b0001; ops[2] = 4'b0010;
    ops[3] = 4'b0110; ops[4] = 4'b0111; ops[5] = 4'b1100;
    undef[0] = 4'b0011; undef[1] = 4'b0100; undef[2] = 4'b1111; undef[3] = 4'b1000;

    // idle state: zero operands, AND (R1, R7)
    apply(32'd0, 32'd0, 4'b0000);
    // R3 carry wrap to zero, unsigned carry without signed overflow
    apply(32'hFFFF_FFFF, 32'd1, 4'b0010);
    // R8 positive overflow on add
    apply(32'h7FFF_FFFF, 32'd1, 4'b0010);
    // R4 / R8 negative overflow on subtract
    apply(32'h8000_0000, 32'd1, 4'b0110);
    // R4 equal operands: zero result, carry set
    apply(32'h1234_5678, 32'h1234_5678, 4'b0110);
    // R4 borrow: carry clear
    apply(32'd3, 32'd5, 4'b0110);
    // R5 overflow corner cases
    apply(32'h8000_0000, 32'd1, 4'b0111);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
    apply(32'hFFFF_FFFF, 32'd0, 4'b0111);
    apply(32'd5, 32'd5, 4'b0111);
    // R6 NOR with zeros gives all ones
    apply(32'd0, 32'd0, 4'b1100);
    apply(32'hF0F0_0000, 32'h0F0F_0000, 4'b1100);
    // R9 undefined codes
    for (int k = 0; k < 4; k++) apply(32'hDEAD_BEEF, 32'h1357_9BDF, undef[k]);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      if (i % 10 == 0) y = x;
      apply(x, y, ops[i % 6]);
    end
    for (int i = 0; i < 32; i++) apply($urandom, $urandom, 4'(i % 16));

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule